// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps the time for a processor core. It holds two 64-bit up-counters, a main time base and an alternate time base, and one 32-bit down-counter, the decrementer. All three step once for every clock in which the shared tick-enable input is high. Software loads any 32-bit half of either time base, or the whole decrementer, through single-cycle write strobes that share one data bus. It reads the current counter values from the output ports.

A run input gates both time bases together. While run is low, their values hold. When run returns high, they continue from the held values. The decrementer ignores run. When the decrementer expires, the block raises an exception request. The request stays high until the core acknowledges it. A mode input picks one of two behaviours:

- **Wrap mode:** the decrementer reloads with all ones when it expires. A software write also raises the request if it moves the sign bit from clear to set.
- **Saturating mode:** the decrementer stops at zero.

Top module: `tbdec_unit`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, both time bases read 0, the decrementer reads 0xFFFFFFFF and dec_exc is low.
- R2: With run high, each cycle with tick_en high and no write to that time base adds exactly one to the full 64-bit value, with carry from bit 31 into bit 32.
- R3: With run low, neither time base changes on tick_en. When run returns high, counting resumes by one per tick from the held value.
- R4: A write strobe for the low half loads wdata into bits 31:0 and keeps bits 63:32. A write strobe for the high half loads bits 63:32 and keeps bits 31:0. Both strobes in one cycle load wdata into both halves.
- R5: A write to one time base leaves the other time base unchanged.
- R6: Each tick_en reduces a nonzero decrementer by one, whatever the level of run. wr_dec loads wdata into the decrementer.
- R7: In wrap mode (dec_saturate = 0), a tick while the decrementer is 0 reloads it with 0xFFFFFFFF and raises dec_exc.
- R8: In wrap mode, wr_dec raises dec_exc exactly when wdata bit 31 is 1 and the current decrementer bit 31 is 0. Any other write leaves dec_exc low.
- R9: In saturating mode (dec_saturate = 1), a tick while the decrementer is 0 keeps it at 0 and raises dec_exc. A write never raises dec_exc in this mode.
- R10: A write strobe in the same cycle as tick_en wins: the written value appears unchanged, for the time bases and for the decrementer.
- R11: dec_exc stays high until a cycle with exc_ack high clears it. A new raise in the same cycle as exc_ack leaves dec_exc high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Counting step for all three counters |
| run | input | 1 | High lets both time bases count |
| dec_saturate | input | 1 | 0 selects wrap mode, 1 selects saturating mode |
| wdata | input | 32 | Shared write data |
| wr_tb_lo | input | 1 | Write main time base bits 31:0 |
| wr_tb_hi | input | 1 | Write main time base bits 63:32 |
| wr_atb_lo | input | 1 | Write alternate time base bits 31:0 |
| wr_atb_hi | input | 1 | Write alternate time base bits 63:32 |
| wr_dec | input | 1 | Write the decrementer |
| exc_ack | input | 1 | Clears the exception request |
| tb_value | output | 64 | Main time base |
| atb_value | output | 64 | Alternate time base |
| dec_value | output | 32 | Decrementer |
| dec_exc | output | 1 | Decrementer exception request |

## Verification
Every output comes straight from a register. A write, a tick, an expiry or an acknowledge that is presented before a clock edge is therefore visible on the ports one cycle later, and no result needs more than one edge.

The bench changes inputs just after a rising edge and reads the outputs just after the next one. It counts edges, not time, to predict each counter value. Sweeps cover:

- carries across the 32-bit boundary,
- freeze and resume with run,
- every pairing of sign states for the write-triggered exception,
- raise and acknowledge arriving in the same cycle.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;

    // Behaviour of the decrementer at zero
    typedef enum logic {
        MODE_WRAP = 1'b0,   // reload all ones, sign-transition writes raise
        MODE_SAT  = 1'b1    // hold at zero
    } dec_mode_e;

    // Half-select write command for one 64-bit time base
    typedef struct packed {
        logic hi;
        logic lo;
    } half_wr_t;

    // Events from the decrementer towards the request latch
    typedef struct packed {
        logic expire;
        logic sign_flip;
    } dec_evt_t;

    localparam int NUM_TB = 2;   // main and alternate time base

    // Raise on a write that takes the sign bit from clear to set
    function automatic logic sign_goes_neg(input logic old_msb, input logic new_msb);
        return new_msb && !old_msb;
    endfunction

endpackage

// File: rtl/tbdec_timebase.sv
module tbdec_timebase
    import tbdec_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    input  half_wr_t            wr,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] value
);
    localparam int FULL_W = 2 * HALF_W;

    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;
    logic [FULL_W-1:0] inc;

    assign inc = {hi_q, lo_q} + FULL_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr.lo || wr.hi) begin
            // a write beats a tick in the same cycle
            if (wr.lo) lo_q <= wdata;
            if (wr.hi) hi_q <= wdata;
        end else if (adv) begin
            {hi_q, lo_q} <= inc;
        end
    end

    assign value = {hi_q, lo_q};
endmodule

// File: rtl/tbdec_decrementer.sv
module tbdec_decrementer
    import tbdec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  dec_mode_e    mode,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output dec_evt_t     evt
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        evt   = '0;
        if (wr) begin
            cnt_d         = wdata;
            evt.sign_flip = (mode == MODE_WRAP) &&
                            sign_goes_neg(cnt_q[W-1], wdata[W-1]);
        end else if (tick) begin
            if (cnt_q == '0) begin
                evt.expire = 1'b1;
                cnt_d      = (mode == MODE_SAT) ? '0 : '1;
            end else begin
                cnt_d = cnt_q - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '1;   // all ones: nothing pending at start
        else     cnt_q <= cnt_d;
    end

    assign value = cnt_q;
endmodule

// File: rtl/tbdec_req_latch.sv
module tbdec_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)      req <= 1'b0;
        else if (set) req <= 1'b1;   // a new raise beats an acknowledge
        else if (ack) req <= 1'b0;
    end
endmodule

// File: rtl/tbdec_unit.sv
module tbdec_unit
    import tbdec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_en,
    input  logic                run,
    input  logic                dec_saturate,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                wr_tb_lo,
    input  logic                wr_tb_hi,
    input  logic                wr_atb_lo,
    input  logic                wr_atb_hi,
    input  logic                wr_dec,
    input  logic                exc_ack,
    output logic [2*DATA_W-1:0] tb_value,
    output logic [2*DATA_W-1:0] atb_value,
    output logic [DATA_W-1:0]   dec_value,
    output logic                dec_exc
);
    localparam int TB_W = 2 * DATA_W;

    half_wr_t        wr_cmd  [NUM_TB];
    logic [TB_W-1:0] tb_vals [NUM_TB];
    dec_evt_t        evt;
    logic            tb_adv;

    assign wr_cmd[0] = '{hi: wr_tb_hi,  lo: wr_tb_lo};
    assign wr_cmd[1] = '{hi: wr_atb_hi, lo: wr_atb_lo};
    assign tb_adv    = tick_en && run;

    for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
        tbdec_timebase #(.HALF_W(DATA_W)) u_tb (
            .clk   (clk),
            .rst   (rst),
            .adv   (tb_adv),
            .wr    (wr_cmd[g]),
            .wdata (wdata),
            .value (tb_vals[g])
        );
    end

    assign tb_value  = tb_vals[0];
    assign atb_value = tb_vals[1];

    tbdec_decrementer #(.W(DATA_W)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_en),
        .mode  (dec_mode_e'(dec_saturate)),
        .wr    (wr_dec),
        .wdata (wdata),
        .value (dec_value),
        .evt   (evt)
    );

    tbdec_req_latch u_req (
        .clk (clk),
        .rst (rst),
        .set (evt.expire || evt.sign_flip),
        .ack (exc_ack),
        .req (dec_exc)
    );
endmodule

// File: rtl/tbdec_checks.sv
module tbdec_checks #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                tick_en,
    input logic                run,
    input logic                dec_saturate,
    input logic [DATA_W-1:0]   wdata,
    input logic                wr_tb_lo,
    input logic                wr_tb_hi,
    input logic                wr_atb_lo,
    input logic                wr_atb_hi,
    input logic                wr_dec,
    input logic                exc_ack,
    input logic [2*DATA_W-1:0] tb_value,
    input logic [2*DATA_W-1:0] atb_value,
    input logic [DATA_W-1:0]   dec_value,
    input logic                dec_exc
);
    logic no_tb_wr;
    assign no_tb_wr = !wr_tb_lo && !wr_tb_hi && !wr_atb_lo && !wr_atb_hi;

    // R2
    a_r2_tb_step: assert property (@(posedge clk) disable iff (rst)
        run && tick_en && no_tb_wr |=> tb_value == $past(tb_value) + 1'b1);

    // R3
    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        !run && no_tb_wr |=> $stable(tb_value) && $stable(atb_value));

    // R4
    a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
        wr_tb_lo && !wr_tb_hi |=>
            tb_value[2*DATA_W-1:DATA_W] == $past(tb_value[2*DATA_W-1:DATA_W]) &&
            tb_value[DATA_W-1:0] == $past(wdata));

    // R4
    a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
        wr_tb_hi && !wr_tb_lo |=>
            tb_value[DATA_W-1:0] == $past(tb_value[DATA_W-1:0]) &&
            tb_value[2*DATA_W-1:DATA_W] == $past(wdata));

    // R5
    a_r5_atb_untouched: assert property (@(posedge clk) disable iff (rst)
        (wr_tb_lo || wr_tb_hi) && !wr_atb_lo && !wr_atb_hi && !(run && tick_en)
            |=> $stable(atb_value));

    // R6
    a_r6_dec_step: assert property (@(posedge clk) disable iff (rst)
        tick_en && !wr_dec && dec_value != '0 |=> dec_value == $past(dec_value) - 1'b1);

    // R7
    a_r7_wrap_expiry: assert property (@(posedge clk) disable iff (rst)
        !dec_saturate && tick_en && !wr_dec && dec_value == '0
            |=> dec_value == '1 && dec_exc);

    // R8
    a_r8_sign_raise: assert property (@(posedge clk) disable iff (rst)
        !dec_saturate && wr_dec && wdata[DATA_W-1] && !dec_value[DATA_W-1] |=> dec_exc);

    // R9
    a_r9_sat_hold: assert property (@(posedge clk) disable iff (rst)
        dec_saturate && tick_en && !wr_dec && dec_value == '0 |=> dec_value == '0 && dec_exc);

    // R10
    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_dec |=> dec_value == $past(wdata));

    // R11
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        dec_exc && !exc_ack |=> dec_exc);

    // R11
    a_r11_clear_needs_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(dec_exc) |-> $past(exc_ack));
endmodule

bind tbdec_unit tbdec_checks #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tbdec_unit_test.sv
module tbdec_unit_test;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          run = 1'b1;
    logic          dec_saturate = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          wr_tb_lo = 1'b0, wr_tb_hi = 1'b0;
    logic          wr_atb_lo = 1'b0, wr_atb_hi = 1'b0;
    logic          wr_dec = 1'b0, exc_ack = 1'b0;
    logic [63:0]   tb_value, atb_value;
    logic [DW-1:0] dec_value;
    logic          dec_exc;

    int total = 0;
    int bad = 0;
    logic [63:0] exp_tb, exp_atb;
    logic [31:0] exp_dec;

    always #5 clk = ~clk;

    tbdec_unit #(.DATA_W(DW)) uut (.*);

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) cyc();
        tick_en = 1'b0;
    endtask

    task automatic ack();
        exc_ack = 1'b1;
        cyc();
        exc_ack = 1'b0;
    endtask

    task automatic wr_dec_val(input logic [31:0] v);
        wdata  = v;
        wr_dec = 1'b1;
        cyc();
        wr_dec = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] vals [5];
        vals = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

        cyc(); cyc();
        // R1 reset values, held while rst is high
        chk("R1 tb", tb_value, 64'd0);
        chk("R1 atb", atb_value, 64'd0);
        chk("R1 dec", {32'd0, dec_value}, 64'hFFFF_FFFF);
        chk("R1 exc", {63'd0, dec_exc}, 64'd0);
        rst = 1'b0;
        cyc();
        chk("R1 tb after release", tb_value, 64'd0);
        exp_dec = 32'hFFFF_FFFF;

        // R2 plain counting
        ticks(10);
        exp_tb = 64'd10; exp_atb = 64'd10; exp_dec -= 32'd10;
        chk("R2 tb count", tb_value, exp_tb);
        chk("R2 atb count", atb_value, exp_atb);

        // R4 / R2 carry sweep
        for (int i = 0; i < 4; i++) begin
            logic [31:0] hv, lv;
            hv = 32'(i * 3 + 1);
            lv = 32'hFFFF_FFFF - 32'(i);
            wdata = hv; wr_tb_hi = 1'b1; cyc(); wr_tb_hi = 1'b0;
            chk("R4 hi write keeps lo", tb_value, {hv, exp_tb[31:0]});
            wdata = lv; wr_tb_lo = 1'b1; cyc(); wr_tb_lo = 1'b0;
            chk("R4 lo write keeps hi", tb_value, {hv, lv});
            chk("R5 atb unaffected", atb_value, exp_atb);
            ticks(i + 2);
            exp_tb  = {hv, lv} + 64'(i + 2);
            exp_atb = exp_atb + 64'(i + 2);
            exp_dec = exp_dec - 32'(i + 2);
            chk("R2 carry into upper half", tb_value, exp_tb);
        end

        // R4 both halves at once
        wdata = 32'h1234_5678; wr_tb_lo = 1'b1; wr_tb_hi = 1'b1; cyc();
        wr_tb_lo = 1'b0; wr_tb_hi = 1'b0;
        exp_tb = 64'h1234_5678_1234_5678;
        chk("R4 both halves", tb_value, exp_tb);

        // R5 alternate write leaves main alone
        wdata = 32'hA5A5_0000; wr_atb_hi = 1'b1; cyc(); wr_atb_hi = 1'b0;
        wdata = 32'h0000_0F00; wr_atb_lo = 1'b1; cyc(); wr_atb_lo = 1'b0;
        exp_atb = 64'hA5A5_0000_0000_0F00;
        chk("R5 atb written", atb_value, exp_atb);
        chk("R5 tb unchanged", tb_value, exp_tb);

        // R3 freeze, R6 decrementer ignores run
        run = 1'b0;
        ticks(7);
        exp_dec -= 32'd7;
        chk("R3 tb frozen", tb_value, exp_tb);
        chk("R3 atb frozen", atb_value, exp_atb);
        chk("R6 dec runs while frozen", {32'd0, dec_value}, {32'd0, exp_dec});
        run = 1'b1;
        ticks(3);
        exp_tb += 64'd3; exp_atb += 64'd3; exp_dec -= 32'd3;
        chk("R3 tb resumes", tb_value, exp_tb);
        chk("R3 atb resumes", atb_value, exp_atb);

        // R10 time base write beats tick
        wdata = 32'h0000_0042; wr_tb_lo = 1'b1; tick_en = 1'b1; cyc();
        wr_tb_lo = 1'b0; tick_en = 1'b0;
        exp_tb = {exp_tb[63:32], 32'h42}; exp_atb += 64'd1;
        chk("R10 tb write over tick", tb_value, exp_tb);
        chk("R10 atb still ticked", atb_value, exp_atb);

        // R6 / R7 wrap expiry
        wr_dec_val(32'd5);
        chk("R6 dec load", {32'd0, dec_value}, 64'd5);
        chk("R8 positive write no raise", {63'd0, dec_exc}, 64'd0);
        ticks(5);
        chk("R6 dec reaches zero", {32'd0, dec_value}, 64'd0);
        chk("R7 no raise at zero", {63'd0, dec_exc}, 64'd0);
        ticks(1);
        chk("R7 reload all ones", {32'd0, dec_value}, 64'hFFFF_FFFF);
        chk("R7 raise on expiry", {63'd0, dec_exc}, 64'd1);
        repeat (3) cyc();
        chk("R11 request sticky", {63'd0, dec_exc}, 64'd1);
        ack();
        chk("R11 ack clears", {63'd0, dec_exc}, 64'd0);

        // R8 sign-transition sweep
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                wr_dec_val(vals[a]);
                ack();
                wr_dec_val(vals[b]);
                chk("R8 dec loaded", {32'd0, dec_value}, {32'd0, vals[b]});
                chk("R8 write raise", {63'd0, dec_exc},
                    {63'd0, vals[b][31] && !vals[a][31]});
            end
        end
        ack();

        // R11 raise and ack in the same cycle
        wr_dec_val(32'd0);
        tick_en = 1'b1; exc_ack = 1'b1; cyc();
        tick_en = 1'b0; exc_ack = 1'b0;
        chk("R11 raise beats ack", {63'd0, dec_exc}, 64'd1);
        ack();

        // R10 decrementer write beats tick
        wdata = 32'd100; wr_dec = 1'b1; tick_en = 1'b1; cyc();
        wr_dec = 1'b0; tick_en = 1'b0;
        chk("R10 dec write over tick", {32'd0, dec_value}, 64'd100);

        // R9 saturating mode
        dec_saturate = 1'b1;
        wr_dec_val(32'd2);
        ticks(4);
        chk("R9 dec holds zero", {32'd0, dec_value}, 64'd0);
        chk("R9 raise at zero", {63'd0, dec_exc}, 64'd1);
        ack();
        wr_dec_val(32'h8000_0000);
        chk("R9 write never raises", {63'd0, dec_exc}, 64'd0);
        ticks(1);
        chk("R9 negative value counts", {32'd0, dec_value}, 64'h7FFF_FFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule